// File: doc/BRIEF.md
# Debug Abstract Command Controller

This block is the command front end of a hart debug unit. A debugger writes a 32-bit command word through a simple register port. The block checks that the word is a supported 32-bit register access. It then hands the command to a hart-side execution engine with a one-cycle start pulse and keeps a busy flag raised until the engine reports completion or an exception.

A 3-bit sticky error code records the first problem seen. The possible problems are: a request made while busy, an unsupported command, or an exception taken by the hart. The debugger clears the code by writing ones to its bits. The block also holds the two data words that commands exchange with the hart, and it reports the data and program buffer sizes in its control/status word.

Busy has no timeout. A hart that never finishes, for example because it can no longer fetch the debug code, leaves busy high. The debugger can see this through the status word.

Top module: `dbg_abscmd_ctrl`

## Requirements
- R1: After reset busy is 0, the error code is 0, no start pulse is issued, and the status word at address 0x16 reads 0x0800_0002.
- R2: The status word carries busy at bit 12, the error code at bits 10:8, the data word count (2) at bits 3:0 and the program buffer size (8) at bits 28:24; all other bits read 0.
- R3: A write to the command address 0x17 is decoded as type [31:24], size [22:20], post-increment [19], post-execute [18], transfer [17], write [16] and register number [15:0]. If busy is 0, the error code is 0, the type is 0, the size is 2, post-increment is 0 and transfer or post-execute is 1, the next cycle shows a start pulse lasting exactly one cycle, busy at 1, and the register number, write, transfer and post-execute flags on the engine outputs.
- R4: Busy stays at 1 for as long as the engine signals neither done nor exception; done clears busy on the next cycle and leaves the error code unchanged.
- R5: An exception from the engine while busy clears busy and sets the error code to 3.
- R6: A command written while busy sets the error code to 1, issues no start pulse and leaves the engine outputs unchanged.
- R7: A write to a data word (0x04, 0x05) or a program buffer word (0x20 to 0x27) while busy sets the error code to 1 and leaves the data words unchanged.
- R8: A command with a type other than 0, a size other than 2 or post-increment set raises error code 2 and issues no start pulse.
- R9: A supported command with transfer and post-execute both 0 completes at once: no start pulse, busy stays 0, no error.
- R10: The error code is sticky: only the first error is recorded, a write of ones to bits 10:8 of the status word clears the matching bits, and commands written while the code is nonzero are ignored.
- R11: The data words at 0x04 and 0x05 are written when busy is 0 and read back at the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Request is a write |
| addr_i | input | 7 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| exec_start_o | output | 1 | One-cycle start pulse to the engine |
| exec_regno_o | output | 16 | Register number of the running command |
| exec_write_o | output | 1 | Command writes the register |
| exec_transfer_o | output | 1 | Command transfers data |
| exec_postexec_o | output | 1 | Command runs the program buffer afterwards |
| exec_done_i | input | 1 | Engine finished the command |
| exec_exc_i | input | 1 | Hart took an exception during the command |

## Verification
Random command words are produced with a bias towards supported ones. Occasional bad types, sizes and post-increment requests separate the "start" case from the "unsupported" case, and no-transfer, no-execute words separate out the "complete at once" case. Each accepted command is held busy for a random number of cycles. During that time, stray command, data and program buffer writes tell the busy rejection apart from a normal launch. Completion by done or by exception separates the error-3 path from a clean finish.

Random partial clear masks exercise the write-ones-to-clear rule. Directed cases cover a very long busy window, a first error that must survive a later exception, and data words that must not change while busy.

// File: rtl/dbg_abscmd_ctrl.sv
module dbg_abscmd_ctrl #(
  parameter int DataCount   = 2,
  parameter int ProgBufSize = 8,
  parameter int AddrW       = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AddrW-1:0]  addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              exec_start_o,
  output logic [15:0]       exec_regno_o,
  output logic              exec_write_o,
  output logic              exec_transfer_o,
  output logic              exec_postexec_o,
  input  logic              exec_done_i,
  input  logic              exec_exc_i
);
  localparam int DIdxW = (DataCount > 1) ? $clog2(DataCount) : 1;
  localparam logic [AddrW-1:0] ADDR_DATA0 = AddrW'(7'h04);
  localparam logic [AddrW-1:0] ADDR_DEND  = AddrW'(7'h04 + DataCount);
  localparam logic [AddrW-1:0] ADDR_CS    = AddrW'(7'h16);
  localparam logic [AddrW-1:0] ADDR_CMD   = AddrW'(7'h17);
  localparam logic [AddrW-1:0] ADDR_PB0   = AddrW'(7'h20);
  localparam logic [AddrW-1:0] ADDR_PEND  = AddrW'(7'h20 + ProgBufSize);

  logic        busy_q, start_q;
  logic [2:0]  cmderr_q, err_set;
  logic [15:0] regno_q;
  logic        write_q, transfer_q, postexec_q;
  logic [31:0] data_q [DataCount];

  wire wr       = req_i & we_i;
  wire in_data  = (addr_i >= ADDR_DATA0) && (addr_i < ADDR_DEND);
  wire in_pb    = (addr_i >= ADDR_PB0) && (addr_i < ADDR_PEND);
  wire hit_cmd  = wr && (addr_i == ADDR_CMD);
  wire hit_cs   = wr && (addr_i == ADDR_CS);
  wire hit_data = wr && in_data;
  wire hit_pb   = wr && in_pb;
  wire [DIdxW-1:0] didx = DIdxW'(addr_i - ADDR_DATA0);

  wire supported = (wdata_i[31:24] == 8'd0) && (wdata_i[22:20] == 3'd2) && !wdata_i[19];
  wire needs_hart = wdata_i[17] | wdata_i[18];
  wire accept = hit_cmd && !busy_q && (cmderr_q == 3'd0);
  wire launch = accept && supported && needs_hart;

  always_comb begin
    if (busy_q && (hit_cmd || hit_data || hit_pb)) err_set = 3'd1;
    else if (accept && !supported)                 err_set = 3'd2;
    else if (busy_q && exec_exc_i)                 err_set = 3'd3;
    else                                           err_set = 3'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
      cmderr_q   <= 3'd0;
      regno_q    <= 16'd0;
      write_q    <= 1'b0;
      transfer_q <= 1'b0;
      postexec_q <= 1'b0;
    end else begin
      start_q <= launch;
      if (launch) begin
        busy_q     <= 1'b1;
        regno_q    <= wdata_i[15:0];
        write_q    <= wdata_i[16];
        transfer_q <= wdata_i[17];
        postexec_q <= wdata_i[18];
      end else if (busy_q && (exec_done_i || exec_exc_i)) begin
        busy_q <= 1'b0;
      end
      if (cmderr_q == 3'd0) cmderr_q <= err_set;
      else if (hit_cs)      cmderr_q <= cmderr_q & ~wdata_i[10:8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DataCount; i++) data_q[i] <= 32'd0;
    end else if (hit_data && !busy_q) begin
      data_q[didx] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = 32'd0;
    if (addr_i == ADDR_CS)
      rdata_o = {3'd0, 5'(ProgBufSize), 11'd0, busy_q, 1'b0, cmderr_q, 4'd0, 4'(DataCount)};
    else if (in_data)
      rdata_o = data_q[didx];
  end

  assign exec_start_o    = start_q;
  assign exec_regno_o    = regno_q;
  assign exec_write_o    = write_q;
  assign exec_transfer_o = transfer_q;
  assign exec_postexec_o = postexec_q;

  AST_START_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |-> (busy_q && !$past(busy_q))); // R3
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |=> !exec_start_o); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !exec_done_i && !exec_exc_i) |=> busy_q); // R4
  AST_EXC_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && exec_exc_i && cmderr_q == 3'd0 && !hit_cmd && !hit_data && !hit_pb)
      |=> (!busy_q && cmderr_q == 3'd3)); // R5
  AST_BUSY_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && hit_cmd) |=> (!exec_start_o && cmderr_q != 3'd0 && $stable(exec_regno_o))); // R6
  AST_UNSUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !supported) |=> (cmderr_q == 3'd2 && !exec_start_o)); // R8
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmderr_q != 3'd0 && !hit_cs) |=> $stable(cmderr_q)); // R10
endmodule

// File: tb/test_dbg_abscmd_ctrl.sv
module test_dbg_abscmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] A_D0 = 7'h04, A_D1 = 7'h05, A_CS = 7'h16, A_CMD = 7'h17, A_PB = 7'h20;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, done = 0, exc = 0;
  logic [6:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic start, wr_o, tr_o, pe_o;
  logic [15:0] regno;

  int checks = 0, errors = 0;
  logic busy_m = 0;
  logic [2:0] cmderr_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_abscmd_ctrl i_dbg_abscmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .exec_start_o(start), .exec_regno_o(regno),
    .exec_write_o(wr_o), .exec_transfer_o(tr_o), .exec_postexec_o(pe_o),
    .exec_done_i(done), .exec_exc_i(exc));

  function automatic int classify(input logic [31:0] c);
    if (c[31:24] != 0 || c[22:20] != 3'd2 || c[19]) return 2;
    if (!c[17] && !c[18]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_cs();
    return {3'd0, 5'd8, 11'd0, busy_m, 1'b0, cmderr_m, 4'd0, 4'd2};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_cmd(input bit with_exc);
    @(negedge clk); done = !with_exc; exc = with_exc;
    @(negedge clk); done = 0; exc = 0;
    busy_m = 0;
    if (with_exc && cmderr_m == 0) cmderr_m = 3;
  endtask

  task automatic chk_cs(input string r);
    logic [31:0] v;
    rd(A_CS, v);
    chk(v == exp_cs(), r, v, exp_cs());
  endtask

  task automatic send_cmd(input logic [31:0] c, input string r);
    bit exp_start;
    exp_start = !busy_m && cmderr_m == 0 && classify(c) == 0;
    wr(A_CMD, c);
    if (busy_m) begin if (cmderr_m == 0) cmderr_m = 1; end
    else if (cmderr_m == 0 && classify(c) == 2) cmderr_m = 2;
    if (exp_start) busy_m = 1;
    chk(start == exp_start, r, {31'd0, start}, {31'd0, exp_start});
    if (exp_start)
      chk({regno, wr_o, tr_o, pe_o} == {c[15:0], c[16], c[17], c[18]}, r,
          {13'd0, regno, wr_o, tr_o, pe_o}, {13'd0, c[15:0], c[16], c[17], c[18]});
    chk_cs(r);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    void'($urandom(32'd4242));
    #(3*CLK_PERIOD) rst_n = 1;
    @(negedge clk);
    // R1 R2 reset state
    rd(A_CS, v); chk(v == 32'h0800_0002, "R1", v, 32'h0800_0002);
    chk(start == 0, "R2", {31'd0, start}, 0);
    // R11 data words
    wr(A_D0, 32'h1111_2222); wr(A_D1, 32'h3333_4444);
    rd(A_D0, v); chk(v == 32'h1111_2222, "R11", v, 32'h1111_2222);
    rd(A_D1, v); chk(v == 32'h3333_4444, "R11", v, 32'h3333_4444);
    // R3 launch, R7 data write while busy
    send_cmd(32'h0023_100a, "R3");
    @(negedge clk); chk(start == 0, "R3", {31'd0, start}, 0);
    wr(A_D0, 32'hAAAA_AAAA); cmderr_m = 1;
    rd(A_D0, v); chk(v == 32'h1111_2222, "R7", v, 32'h1111_2222);
    chk_cs("R7");
    // R4 long busy
    repeat (50) @(negedge clk);
    chk_cs("R4");
    // R10 first error survives exception
    finish_cmd(1); chk_cs("R10");
    send_cmd(32'h0023_100b, "R10");
    wr(A_CS, 32'h0000_0200); chk_cs("R10");
    wr(A_CS, 32'h0000_0700); cmderr_m = 0; chk_cs("R10");
    // R9 trivial
    send_cmd(32'h0020_0000, "R9");
    // R8 unsupported
    send_cmd(32'h0123_1000, "R8");
    wr(A_CS, 32'h700); cmderr_m = 0;
    send_cmd(32'h0013_1000, "R8");
    wr(A_CS, 32'h700); cmderr_m = 0;
    // R5 exception
    send_cmd(32'h0023_03a3, "R5");
    finish_cmd(1); chk_cs("R5");
    wr(A_CS, 32'h700); cmderr_m = 0;
    // R6 command while busy, R7 program buffer while busy
    send_cmd(32'h0022_1008, "R6");
    send_cmd(32'h0022_1001, "R6");
    chk(regno == 16'h1008, "R6", {16'd0, regno}, 32'h1008);
    finish_cmd(0); chk_cs("R4");
    wr(A_CS, 32'h700); cmderr_m = 0;
    send_cmd(32'h0026_1002, "R3");
    wr(A_PB + 7'd3, 32'h13); cmderr_m = 1; chk_cs("R7");
    finish_cmd(0); chk_cs("R4");
    wr(A_CS, 32'h700); cmderr_m = 0;

    // random
    for (int i = 0; i < 400; i++) begin
      c = 32'd0;
      c[31:24] = ($urandom % 8 == 0) ? 8'($urandom) : 8'd0;
      c[22:20] = ($urandom % 6 == 0) ? 3'($urandom) : 3'd2;
      c[19] = ($urandom % 10 == 0);
      c[18] = ($urandom % 4 == 0);
      c[17] = ($urandom % 5 != 0);
      c[16] = 1'($urandom);
      c[15:0] = ($urandom % 2) ? 16'(16'h1000 + $urandom % 32) : 16'($urandom % 4096);
      send_cmd(c, "R3");
      if (busy_m) begin
        for (int k = 0; k < int'($urandom % 4); k++) begin
          case ($urandom % 4)
            0: send_cmd(32'h0023_1005, "R6");
            1: begin wr(A_D1, $urandom); if (cmderr_m == 0) cmderr_m = 1; chk_cs("R7"); end
            2: begin wr(A_PB, $urandom); if (cmderr_m == 0) cmderr_m = 1; chk_cs("R7"); end
            default: begin @(negedge clk); chk_cs("R4"); end
          endcase
        end
        finish_cmd($urandom % 4 == 0);
        chk_cs("R5");
      end
      if ($urandom % 3 == 0) begin
        logic [2:0] m;
        m = 3'($urandom);
        wr(A_CS, {21'd0, m, 8'd0});
        cmderr_m = cmderr_m & ~m;
        chk_cs("R10");
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule